// File: doc/BRIEF.md
# Floppy drive control port

This block is a byte-wide register front end placed between a small processor I/O bus and a floppy drive cable. It answers seven consecutive port addresses starting at a base address. Bus writes latch the drive control lines and a 3-bit output select field. Further writes set or clear one output in a bank of eight latched outputs. Output 0 of that bank is the head-load line, and outputs 1 to 7 are general-purpose cable outputs.

Bus reads return the raw active-low drive status lines, together with the state of the currently selected bank output. A read or write to a dedicated wait port stalls the processor until the serial receiver holds a byte, or until the transmitter buffer is empty. Bytes move to and from an external synchronous serial engine through single-cycle strobes. The block also issues strobes that load the engine's fill byte and sync byte and that reset its receiver.

All bus accesses are single-cycle qualified by `bus_rd` or `bus_wr`. Read data and strobes are combinational from the current access. Latched state changes on the clock edge that ends a write.

Top module: `flop_drive_port`

## Requirements
- R1: A synchronous active-high `rst` clears the five control outputs, the select field `out_sel` and all eight bank outputs `bank_out` to zero.
- R2: A write to offset 3 (base+3) loads `wr_cur_sel`, `unsafe_rst`, `step_dir`, `wr_gate` and `step` from data bits 0, 1, 2, 3 and 4 respectively, visible after that clock edge.
- R3: The same offset-3 write loads `out_sel` from data bits 7:5. Select value 0 addresses `bank_out[0]` (head load), and value k addresses `bank_out[k]`.
- R4: A write to offset 5 sets the bank output addressed by `out_sel` and leaves all other bank outputs unchanged, whatever the data byte is.
- R5: A write to offset 6 clears the bank output addressed by `out_sel` and leaves the others unchanged, whatever the data byte is.
- R6: A read of offset 1 returns `trk0_n`, `unsafe_n`, `ready_n`, `sector_n` and `index_n` unaltered in bits 0, 1, 2, 3 and 4, with bits 7:6 zero.
- R7: Bit 5 of an offset-1 read equals the bank output currently addressed by `out_sel`.
- R8: A read of offset 3 raises `ser_rx_rst` for that cycle and leaves every latched output unchanged.
- R9: While a read of offset 4 is on the bus, `bus_wait` is high exactly while `ser_rx_avail` is low, and it drops in the same cycle `ser_rx_avail` rises.
- R10: While a write of offset 4 is on the bus, `bus_wait` is high exactly while `ser_tx_empty` is low. `bus_wait` is low whenever no offset-4 access is present.
- R11: A write of offset 0 raises `ser_tx_wr` with `ser_tx_data` equal to the bus data. A read of offset 0 raises `ser_rx_rd` and returns `ser_rx_data`.
- R12: A write of offset 1 raises `ser_fill_wr`, and a write of offset 2 raises `ser_sync_wr`, each carrying the bus data on `ser_tx_data`. A read of offset 2 returns `ser_status`.
- R13: An access to an address outside base..base+6 raises no strobe, no wait, reads zero and changes no latched output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Port address |
| bus_rd | input | 1 | Read cycle qualifier |
| bus_wr | input | 1 | Write cycle qualifier |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_wait | output | 1 | Stall request to the processor |
| trk0_n | input | 1 | Track-zero status, active low |
| unsafe_n | input | 1 | File-unsafe status, active low |
| ready_n | input | 1 | Drive-ready status, active low |
| sector_n | input | 1 | Sector pulse, active low |
| index_n | input | 1 | Index pulse, active low |
| wr_cur_sel | output | 1 | Write-current select |
| unsafe_rst | output | 1 | Unsafe-condition reset |
| step_dir | output | 1 | Step direction |
| wr_gate | output | 1 | Write gate |
| step | output | 1 | Step line |
| out_sel | output | 3 | Bank output select field |
| bank_out | output | 8 | Latched bank outputs, bit 0 head load |
| ser_rx_data | input | 8 | Received byte from the serial engine |
| ser_rx_avail | input | 1 | Receiver holds a byte |
| ser_tx_empty | input | 1 | Transmit buffer empty |
| ser_status | input | 8 | Serial engine status byte |
| ser_tx_data | output | 8 | Byte for transmit, fill or sync load |
| ser_tx_wr | output | 1 | Transmit byte strobe |
| ser_rx_rd | output | 1 | Receive byte taken strobe |
| ser_fill_wr | output | 1 | Fill byte load strobe |
| ser_sync_wr | output | 1 | Sync byte load strobe |
| ser_rx_rst | output | 1 | Receiver reset strobe |

## Verification
The hardest situation to reach is the indirect addressing of the bank. A given bank bit can only be set, cleared or read through a prior control write that points the select field at it. A mistake in select decoding shows up only when other bank bits already hold differing values. The stimulus therefore builds a known mixed pattern across several select values first. It then re-points the select, checks set, clear and the status bit 5 readback against a bench model, and ends with stalled wait accesses where the awaited condition rises in the middle of the cycle.

// File: rtl/flop_drive_pkg.sv
package flop_drive_pkg;
   localparam int unsigned PORT_COUNT = 7;

   typedef enum logic [2:0] {
      OFS_DATA   = 3'd0,
      OFS_STAT   = 3'd1,
      OFS_SER    = 3'd2,
      OFS_CTRL   = 3'd3,
      OFS_WAIT   = 3'd4,
      OFS_TRIG   = 3'd5,
      OFS_CLR    = 3'd6
   } port_ofs_e;

   typedef struct packed {
      logic data;
      logic stat;
      logic ser;
      logic ctrl;
      logic wt;
      logic trig;
      logic clr;
   } port_hit_t;
endpackage

// File: rtl/flop_port_decode.sv
module flop_port_decode
   import flop_drive_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [7:0]  BASE_ADDR = 8'hF0
) (
   input  logic [ADDR_W-1:0] addr,
   output port_hit_t         hit
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   if (ADDR_W < 3) begin : g_bad_width
      $error("flop_port_decode: ADDR_W must be at least 3");
   end

   logic [ADDR_W-1:0] ofs;
   logic              in_win;

   always_comb begin
      ofs    = addr - BASE;
      in_win = (addr >= BASE) && (ofs < ADDR_W'(PORT_COUNT));
      hit.data = in_win && (ofs[2:0] == OFS_DATA);
      hit.stat = in_win && (ofs[2:0] == OFS_STAT);
      hit.ser  = in_win && (ofs[2:0] == OFS_SER);
      hit.ctrl = in_win && (ofs[2:0] == OFS_CTRL);
      hit.wt   = in_win && (ofs[2:0] == OFS_WAIT);
      hit.trig = in_win && (ofs[2:0] == OFS_TRIG);
      hit.clr  = in_win && (ofs[2:0] == OFS_CLR);
   end

   always_comb begin
      AST_HIT_ONEHOT: assert ($onehot0(hit)); // R13
   end
endmodule

// File: rtl/flop_ctrl_reg.sv
module flop_ctrl_reg #(
   parameter int unsigned CTRL_W = 5,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned SEL_LSB = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [7:0]        wdata,
   output logic [CTRL_W-1:0] ctrl,
   output logic [SEL_W-1:0]  sel
);
   if (CTRL_W > SEL_LSB || SEL_LSB + SEL_W > 8) begin : g_bad_fields
      $error("flop_ctrl_reg: control and select fields overlap or overflow the byte");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl <= '0;
         sel  <= '0;
      end else if (load) begin
         ctrl <= wdata[CTRL_W-1:0];
         sel  <= wdata[SEL_LSB +: SEL_W];
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(ctrl) && $stable(sel))); // R8
   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> (ctrl == $past(wdata[CTRL_W-1:0]))); // R2
   AST_CTRL_RESET: assert property (@(posedge clk)
      rst |=> (ctrl == '0 && sel == '0)); // R1
endmodule

// File: rtl/flop_out_bank.sv
module flop_out_bank #(
   parameter int unsigned NUM_OUT = 8,
   localparam int unsigned SEL_W  = $clog2(NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [SEL_W-1:0]   sel,
   input  logic               set_stb,
   input  logic               clr_stb,
   output logic [NUM_OUT-1:0] q,
   output logic               sel_q
);
   if (NUM_OUT < 2 || NUM_OUT != (1 << SEL_W)) begin : g_bad_count
      $error("flop_out_bank: NUM_OUT must be a power of two of at least 2");
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
      logic hit;
      assign hit = (sel == SEL_W'(i));
      always_ff @(posedge clk) begin
         if (rst)
            q[i] <= 1'b0;
         else if (hit && set_stb)
            q[i] <= 1'b1;
         else if (hit && clr_stb)
            q[i] <= 1'b0;
      end
   end

   assign sel_q = q[sel];

   AST_BANK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ($countones(q ^ $past(q)) <= 1)); // R4
   AST_BANK_SET: assert property (@(posedge clk) disable iff (rst)
      set_stb |=> q[$past(sel)]); // R4
   AST_BANK_CLR: assert property (@(posedge clk) disable iff (rst)
      (clr_stb && !set_stb) |=> !q[$past(sel)]); // R5
   AST_BANK_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!set_stb && !clr_stb) |=> $stable(q)); // R13
endmodule

// File: rtl/flop_drive_port.sv
module flop_drive_port
   import flop_drive_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [7:0]  BASE_ADDR = 8'hF0,
   parameter int unsigned NUM_OUT   = 8,
   localparam int unsigned SEL_W    = $clog2(NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               bus_wait,
   input  logic               trk0_n,
   input  logic               unsafe_n,
   input  logic               ready_n,
   input  logic               sector_n,
   input  logic               index_n,
   output logic               wr_cur_sel,
   output logic               unsafe_rst,
   output logic               step_dir,
   output logic               wr_gate,
   output logic               step,
   output logic [SEL_W-1:0]   out_sel,
   output logic [NUM_OUT-1:0] bank_out,
   input  logic [7:0]         ser_rx_data,
   input  logic               ser_rx_avail,
   input  logic               ser_tx_empty,
   input  logic [7:0]         ser_status,
   output logic [7:0]         ser_tx_data,
   output logic               ser_tx_wr,
   output logic               ser_rx_rd,
   output logic               ser_fill_wr,
   output logic               ser_sync_wr,
   output logic               ser_rx_rst
);
   localparam int unsigned CTRL_W  = 5;
   localparam int unsigned SEL_LSB = 5;

   if (SEL_W > 3) begin : g_bad_sel
      $error("flop_drive_port: select field must fit in data bits 7:5");
   end

   port_hit_t         hit;
   logic [CTRL_W-1:0] ctrl;
   logic              sel_state;

   flop_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (bus_addr),
      .hit  (hit)
   );

   flop_ctrl_reg #(.CTRL_W(CTRL_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .load  (bus_wr && hit.ctrl),
      .wdata (bus_wdata),
      .ctrl  (ctrl),
      .sel   (out_sel)
   );

   flop_out_bank #(.NUM_OUT(NUM_OUT)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .sel     (out_sel),
      .set_stb (bus_wr && hit.trig),
      .clr_stb (bus_wr && hit.clr),
      .q       (bank_out),
      .sel_q   (sel_state)
   );

   assign {step, wr_gate, step_dir, unsafe_rst, wr_cur_sel} = ctrl;

   assign ser_tx_data = bus_wdata;
   assign ser_tx_wr   = bus_wr && hit.data;
   assign ser_fill_wr = bus_wr && hit.stat;
   assign ser_sync_wr = bus_wr && hit.ser;
   assign ser_rx_rd   = bus_rd && hit.data;
   assign ser_rx_rst  = bus_rd && hit.ctrl;

   assign bus_wait = hit.wt && ((bus_rd && !ser_rx_avail) || (bus_wr && !ser_tx_empty));

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd) begin
         if (hit.data)
            bus_rdata = ser_rx_data;
         else if (hit.stat)
            bus_rdata = {2'b00, sel_state, index_n, sector_n, ready_n, unsafe_n, trk0_n};
         else if (hit.ser)
            bus_rdata = ser_status;
      end
   end

   AST_WAIT_RX_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && ser_rx_avail) |-> !bus_wait); // R9
   AST_WAIT_TX_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && ser_tx_empty) |-> !bus_wait); // R10
   AST_RXRST_NO_STATE: assert property (@(posedge clk) disable iff (rst)
      ser_rx_rst |=> ($stable(bank_out) && $stable(out_sel))); // R8
endmodule

// File: tb/tb_flop_drive_port.sv
module tb_flop_drive_port;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] BASE = 8'hF0;

   logic clk = 1'b0;
   logic rst;
   logic [7:0] bus_addr, bus_wdata, bus_rdata;
   logic bus_rd, bus_wr, bus_wait;
   logic trk0_n, unsafe_n, ready_n, sector_n, index_n;
   logic wr_cur_sel, unsafe_rst, step_dir, wr_gate, step;
   logic [2:0] out_sel;
   logic [7:0] bank_out;
   logic [7:0] ser_rx_data, ser_status, ser_tx_data;
   logic ser_rx_avail, ser_tx_empty;
   logic ser_tx_wr, ser_rx_rd, ser_fill_wr, ser_sync_wr, ser_rx_rst;

   int checks = 0;
   int errors = 0;
   logic [7:0] model_bank;

   always #(CLK_PERIOD/2) clk = ~clk;

   flop_drive_port dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
      .trk0_n(trk0_n), .unsafe_n(unsafe_n), .ready_n(ready_n), .sector_n(sector_n),
      .index_n(index_n), .wr_cur_sel(wr_cur_sel), .unsafe_rst(unsafe_rst),
      .step_dir(step_dir), .wr_gate(wr_gate), .step(step), .out_sel(out_sel),
      .bank_out(bank_out), .ser_rx_data(ser_rx_data), .ser_rx_avail(ser_rx_avail),
      .ser_tx_empty(ser_tx_empty), .ser_status(ser_status), .ser_tx_data(ser_tx_data),
      .ser_tx_wr(ser_tx_wr), .ser_rx_rd(ser_rx_rd), .ser_fill_wr(ser_fill_wr),
      .ser_sync_wr(ser_sync_wr), .ser_rx_rst(ser_rx_rst)
   );

   // status input vectors {index,sector,ready,unsafe,trk0} with select value to use
   localparam int NV = 6;
   localparam logic [4:0] V_IN [NV]  = '{5'b00000, 5'b11111, 5'b10101, 5'b01010, 5'b00001, 5'b10000};
   localparam logic [2:0] V_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd6, 3'd7};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      idle();
   endtask

   task automatic wr_bank(input bit set, input logic [2:0] s, input logic [7:0] junk);
      wr(BASE + 8'd3, {s, 5'b00000});
      wr(set ? BASE + 8'd5 : BASE + 8'd6, junk);
      if (set) model_bank[s] = 1'b1; else model_bank[s] = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      {trk0_n, unsafe_n, ready_n, sector_n, index_n} = 5'b11111;
      ser_rx_data = 8'h00; ser_status = 8'h00; ser_rx_avail = 1'b0; ser_tx_empty = 1'b0;
      model_bank = 8'h00;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ctrl", {wr_cur_sel, unsafe_rst, step_dir, wr_gate, step}, 0);
      check("R1 sel", out_sel, 0);
      check("R1 bank", bank_out, 0);
      rst = 1'b0;

      // R2 / R3 control write
      wr(BASE + 8'd3, 8'b101_10110);
      check("R2 wr_cur_sel", wr_cur_sel, 0);
      check("R2 unsafe_rst", unsafe_rst, 1);
      check("R2 step_dir", step_dir, 1);
      check("R2 wr_gate", wr_gate, 0);
      check("R2 step", step, 1);
      check("R3 sel", out_sel, 3'd5);
      wr(BASE + 8'd3, 8'b010_01001);
      check("R2 pattern2", {step, wr_gate, step_dir, unsafe_rst, wr_cur_sel}, 5'b01001);
      check("R3 sel2", out_sel, 3'd2);

      // R4 build a mixed bank pattern, data byte varies
      wr_bank(1, 3'd0, 8'h00);
      check("R3 head load bit0", bank_out, 8'h01);
      wr_bank(1, 3'd3, 8'hFF);
      wr_bank(1, 3'd6, 8'h5A);
      wr_bank(1, 3'd7, 8'h00);
      check("R4 set pattern", bank_out, model_bank);
      // R5 clear only selected
      wr_bank(0, 3'd3, 8'hFF);
      check("R5 clear one", bank_out, model_bank);
      wr_bank(0, 3'd1, 8'hA5);
      check("R5 clear already-low", bank_out, model_bank);

      // R6 / R7 table walk
      for (int i = 0; i < NV; i++) begin
         wr(BASE + 8'd3, {V_SEL[i], 5'b00000});
         @(negedge clk);
         {index_n, sector_n, ready_n, unsafe_n, trk0_n} = V_IN[i];
         bus_addr = BASE + 8'd1; bus_rd = 1'b1;
         #1;
         check("R6 R7 status", bus_rdata, {2'b00, model_bank[V_SEL[i]], V_IN[i]});
         @(negedge clk);
         idle();
      end

      // R8 read control address
      @(negedge clk);
      bus_addr = BASE + 8'd3; bus_rd = 1'b1;
      #1;
      check("R8 rx reset strobe", ser_rx_rst, 1);
      @(negedge clk);
      idle();
      #1;
      check("R8 strobe drops", ser_rx_rst, 0);
      check("R8 bank unchanged", bank_out, model_bank);
      check("R8 sel unchanged", out_sel, V_SEL[NV-1]);

      // R9 wait on read
      @(negedge clk);
      ser_rx_avail = 1'b0;
      bus_addr = BASE + 8'd4; bus_rd = 1'b1;
      #1;
      check("R9 wait held", bus_wait, 1);
      @(posedge clk); #2;
      check("R9 wait still held", bus_wait, 1);
      ser_rx_avail = 1'b1;
      #1;
      check("R9 wait released same cycle", bus_wait, 0);
      @(negedge clk);
      idle();
      // R10 wait on write
      ser_tx_empty = 1'b0;
      bus_addr = BASE + 8'd4; bus_wr = 1'b1;
      #1;
      check("R10 wait held", bus_wait, 1);
      ser_tx_empty = 1'b1;
      #1;
      check("R10 wait released", bus_wait, 0);
      @(negedge clk);
      idle();
      ser_tx_empty = 1'b0; ser_rx_avail = 1'b0;
      #1;
      check("R10 no access no wait", bus_wait, 0);

      // R11 data port
      bus_addr = BASE; bus_wr = 1'b1; bus_wdata = 8'hC3;
      #1;
      check("R11 tx strobe", {ser_tx_wr, ser_fill_wr, ser_sync_wr}, 3'b100);
      check("R11 tx data", ser_tx_data, 8'hC3);
      @(negedge clk);
      idle();
      ser_rx_data = 8'h81;
      bus_addr = BASE; bus_rd = 1'b1;
      #1;
      check("R11 rx strobe", ser_rx_rd, 1);
      check("R11 rx data", bus_rdata, 8'h81);
      @(negedge clk);
      idle();

      // R12 fill / sync / serial status
      bus_addr = BASE + 8'd1; bus_wr = 1'b1; bus_wdata = 8'h4E;
      #1;
      check("R12 fill strobe", {ser_tx_wr, ser_fill_wr, ser_sync_wr}, 3'b010);
      check("R12 fill data", ser_tx_data, 8'h4E);
      @(negedge clk);
      bus_addr = BASE + 8'd2; bus_wdata = 8'h81;
      #1;
      check("R12 sync strobe", {ser_tx_wr, ser_fill_wr, ser_sync_wr}, 3'b001);
      @(negedge clk);
      idle();
      ser_status = 8'h3C;
      bus_addr = BASE + 8'd2; bus_rd = 1'b1;
      #1;
      check("R12 serial status", bus_rdata, 8'h3C);
      @(negedge clk);
      idle();

      // R13 out-of-window accesses
      foreach (V_SEL[k]) begin end
      for (int a = 0; a < 3; a++) begin
         logic [7:0] adr;
         adr = (a == 0) ? BASE + 8'd7 : (a == 1) ? BASE - 8'd1 : 8'h05;
         @(negedge clk);
         bus_addr = adr; bus_wr = 1'b1; bus_wdata = 8'hFF;
         #1;
         check("R13 no write strobe", {ser_tx_wr, ser_fill_wr, ser_sync_wr, bus_wait}, 0);
         @(negedge clk);
         bus_wr = 1'b0; bus_rd = 1'b1;
         #1;
         check("R13 read zero", {bus_rdata, ser_rx_rd, ser_rx_rst, bus_wait}, 0);
         @(negedge clk);
         idle();
         #1;
         check("R13 bank unchanged", bank_out, model_bank);
         check("R13 ctrl unchanged", {out_sel, step, wr_gate, step_dir, unsafe_rst, wr_cur_sel},
               {V_SEL[NV-1], 5'b00000});
      end

      // R1 reset from a busy state
      wr(BASE + 8'd3, 8'hFF);
      wr(BASE + 8'd5, 8'h00);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset clears all", {out_sel, bank_out, step, wr_gate, step_dir, unsafe_rst, wr_cur_sel}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule